// File: doc/BRIEF.md
# Flag-qualified I/O interrupt requester

This block sits beside one I/O channel and decides whether the events that occur during a transfer should raise an interrupt toward the processor. The enable flags come from the command doubleword that is currently in force and are held steady on plain input pins. Each event arrives as a one-cycle pulse. Every event has its own flag rule. Some events need one flag, some need two, one of them can be suppressed by a third flag, and hard internal errors need no flag at all.

The block also collects a status word. Each event sets its own fixed status bits, and it does so whether or not its flag lets an interrupt through. The request and the status word are sticky. A single `ack` pulse from the interrupt acknowledge clears both of them. An event that lands in the same cycle as `ack` survives the clear. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `io_irq_req`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it goes high, `irq_req` is 0 and `status` is all zeros.
- R2: A pulse on `ev_count_zero` sets status bit 10 (bit 0 is the LSB). It raises `irq_req` only if `flag_zero_ie` is 1.
- R3: A pulse on `ev_chan_end` sets status bit 11. It raises `irq_req` only if `flag_end_ie` is 1.
- R4: A pulse on `ev_mem_err` or on `ev_wr_protect` sets status bit 12. It raises `irq_req` only if `flag_unusual_ie` and `flag_halt_err` are both 1.
- R5: A pulse on `ev_bad_length` sets status bits 8 and 12. It raises `irq_req` only if `flag_unusual_ie` is 1, `flag_halt_err` is 1 and `flag_len_quiet` is 0.
- R6: A pulse on `ev_hard_err` sets status bits 9 and 12. It raises `irq_req` for every combination of the flags.
- R7: A pulse on `ev_halt` sets status bits 12 and 14. It raises `irq_req` only if `flag_unusual_ie` is 1.
- R8: `irq_req` and every status bit stay set until `ack` is high at a clock edge. After an edge with `ack` high and no event, both are zero.
- R9: An event that is high in the same cycle as `ack` is kept. After that edge, `irq_req` and `status` reflect only the events of that cycle.
- R10: When several events occur together or over successive cycles, `irq_req` rises if any one of them is enabled by its flags, and `status` is the OR of their bits.
- R11: Status bits other than 8, 9, 10, 11, 12 and 14 are always 0.
- R12: Outputs change only on the clock edge that follows the event. An event or `ack` seen at edge t shows on the outputs after edge t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_zero_ie | input | 1 | Enable an interrupt when the byte count reaches zero |
| flag_end_ie | input | 1 | Enable an interrupt on channel end |
| flag_unusual_ie | input | 1 | Enable an interrupt on unusual conditions |
| flag_halt_err | input | 1 | Treat transfer errors as halting (needed for the error interrupts) |
| flag_len_quiet | input | 1 | Suppress the interrupt for an incorrect length |
| ev_count_zero | input | 1 | Pulse: the byte count has reached zero |
| ev_chan_end | input | 1 | Pulse: channel end |
| ev_mem_err | input | 1 | Pulse: memory error during the transfer |
| ev_wr_protect | input | 1 | Pulse: write-lock violation |
| ev_bad_length | input | 1 | Pulse: incorrect length |
| ev_halt | input | 1 | Pulse: the channel processor halted |
| ev_hard_err | input | 1 | Pulse: hard internal error (always interrupts) |
| ack | input | 1 | Interrupt acknowledge: clears the request and the status |
| irq_req | output | 1 | Sticky interrupt request |
| status | output | STAT_W | Sticky condition status word |

## Verification
The hardest case to reach from the ports is an event that coincides with `ack` while earlier conditions are still pending. A wrong clear priority would either drop the new event or keep stale bits. Only that overlap separates the two.

The stimulus first loads status and a request, then fires one event together with `ack` under both a permitting flag set and a suppressing one. A long random phase follows. In that phase `ack` is high in about a quarter of the cycles, so collisions between `ack` and several events recur under random flag mixes.

// File: rtl/io_irq_pkg.sv
package io_irq_pkg;

  localparam int NEV = 7;

  // event indices
  localparam int EV_CNT0   = 0;
  localparam int EV_CEND   = 1;
  localparam int EV_MEMERR = 2;
  localparam int EV_WPROT  = 3;
  localparam int EV_BADLEN = 4;
  localparam int EV_HALT   = 5;
  localparam int EV_HARD   = 6;

  // status bit positions
  localparam int SB_LEN  = 8;
  localparam int SB_HARD = 9;
  localparam int SB_CNT0 = 10;
  localparam int SB_CEND = 11;
  localparam int SB_ERR  = 12;
  localparam int SB_HALT = 14;

  localparam logic [31:0] USED_MASK =
    (32'd1 << SB_LEN) | (32'd1 << SB_HARD) | (32'd1 << SB_CNT0) |
    (32'd1 << SB_CEND) | (32'd1 << SB_ERR) | (32'd1 << SB_HALT);

  typedef struct packed {
    logic len_quiet;
    logic halt_err;
    logic unusual;
    logic end_ie;
    logic zero_ie;
  } flags_t;

  // flag rule for one event
  function automatic logic ev_gate(input int idx, input flags_t f);
    case (idx)
      EV_CNT0:             return f.zero_ie;
      EV_CEND:             return f.end_ie;
      EV_MEMERR, EV_WPROT: return f.unusual & f.halt_err;
      EV_BADLEN:           return f.unusual & f.halt_err & ~f.len_quiet;
      EV_HALT:             return f.unusual;
      EV_HARD:             return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  // status bits set by one event
  function automatic logic [31:0] ev_mask(input int idx);
    case (idx)
      EV_CNT0:             return 32'd1 << SB_CNT0;
      EV_CEND:             return 32'd1 << SB_CEND;
      EV_MEMERR, EV_WPROT: return 32'd1 << SB_ERR;
      EV_BADLEN:           return (32'd1 << SB_LEN) | (32'd1 << SB_ERR);
      EV_HALT:             return (32'd1 << SB_HALT) | (32'd1 << SB_ERR);
      EV_HARD:             return (32'd1 << SB_HARD) | (32'd1 << SB_ERR);
      default:             return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import io_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  flags_t         flg,
  input  logic [NEV-1:0] ev,
  output logic [NEV-1:0] req
);

  for (genvar g = 0; g < NEV; g++) begin : g_gate
    assign req[g] = ev[g] & ev_gate(g, flg);
  end

  assert_len_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flg.len_quiet |-> !req[EV_BADLEN]);

  assert_cnt0_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[EV_CNT0] && !flg.zero_ie) |-> !req[EV_CNT0]);

  assert_err_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(flg.unusual && flg.halt_err) |-> !(req[EV_MEMERR] || req[EV_WPROT]));

endmodule

// File: rtl/stat_map.sv
module stat_map
  import io_irq_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    ev,
  output logic [STAT_W-1:0] set_mask
);

  logic [STAT_W-1:0] per_ev [NEV];

  for (genvar g = 0; g < NEV; g++) begin : g_map
    localparam logic [31:0] M = ev_mask(g);
    assign per_ev[g] = ev[g] ? M[STAT_W-1:0] : '0;
  end

  always_comb begin
    set_mask = '0;
    for (int i = 0; i < NEV; i++) set_mask = set_mask | per_ev[i];
  end

  assert_halt_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_HALT] |-> (set_mask[SB_HALT] && set_mask[SB_ERR]));

  assert_cnt0_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_CNT0] |-> set_mask[SB_CNT0]);

endmodule

// File: rtl/sticky_reg.sv
module sticky_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | set;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q)));

  assert_clear_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == $past(set)));

endmodule

// File: rtl/io_irq_req.sv
module io_irq_req
  import io_irq_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_zero_ie,
  input  logic              flag_end_ie,
  input  logic              flag_unusual_ie,
  input  logic              flag_halt_err,
  input  logic              flag_len_quiet,
  input  logic              ev_count_zero,
  input  logic              ev_chan_end,
  input  logic              ev_mem_err,
  input  logic              ev_wr_protect,
  input  logic              ev_bad_length,
  input  logic              ev_halt,
  input  logic              ev_hard_err,
  input  logic              ack,
  output logic              irq_req,
  output logic [STAT_W-1:0] status
);

  localparam logic [STAT_W-1:0] USED = USED_MASK[STAT_W-1:0];

  flags_t            flg;
  logic [NEV-1:0]    ev;
  logic [NEV-1:0]    req;
  logic [STAT_W-1:0] set_mask;
  logic              any_req;

  assign flg = '{len_quiet: flag_len_quiet, halt_err: flag_halt_err,
                 unusual: flag_unusual_ie, end_ie: flag_end_ie,
                 zero_ie: flag_zero_ie};

  always_comb begin
    ev            = '0;
    ev[EV_CNT0]   = ev_count_zero;
    ev[EV_CEND]   = ev_chan_end;
    ev[EV_MEMERR] = ev_mem_err;
    ev[EV_WPROT]  = ev_wr_protect;
    ev[EV_BADLEN] = ev_bad_length;
    ev[EV_HALT]   = ev_halt;
    ev[EV_HARD]   = ev_hard_err;
  end

  evt_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .flg(flg), .ev(ev), .req(req)
  );

  stat_map #(.STAT_W(STAT_W)) u_map (
    .clk(clk), .rst_n(rst_n), .ev(ev), .set_mask(set_mask)
  );

  assign any_req = |req;

  sticky_reg #(.W(1)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(ack), .set(any_req), .q(irq_req)
  );

  sticky_reg #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(ack), .set(set_mask), .q(status)
  );

  assert_hard_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hard_err |=> irq_req);

  assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(|ev)) |=> (!irq_req && status == '0));

  assert_spare_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~USED) == '0);

  assert_no_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !(|ev)) |=> ($stable(irq_req) && $stable(status)));

endmodule

// File: tb/test_io_irq_req.sv
module test_io_irq_req;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] fl;   // {len_quiet, halt_err, unusual, end_ie, zero_ie}
  logic [6:0] ev;   // {hard, halt, bad_len, wr_prot, mem_err, chan_end, count_zero}
  logic ack;
  logic irq_req;
  logic [SW-1:0] status;

  int total = 0;
  int bad = 0;
  logic exp_irq;
  logic [SW-1:0] exp_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_irq_req #(.STAT_W(SW)) i_io_irq_req (
    .clk(clk), .rst_n(rst_n),
    .flag_zero_ie(fl[0]), .flag_end_ie(fl[1]), .flag_unusual_ie(fl[2]),
    .flag_halt_err(fl[3]), .flag_len_quiet(fl[4]),
    .ev_count_zero(ev[0]), .ev_chan_end(ev[1]), .ev_mem_err(ev[2]),
    .ev_wr_protect(ev[3]), .ev_bad_length(ev[4]), .ev_halt(ev[5]),
    .ev_hard_err(ev[6]), .ack(ack), .irq_req(irq_req), .status(status)
  );

  task automatic check(input string tag);
    total++;
    if (irq_req !== exp_irq) begin
      bad++;
      $display("FAIL %s irq_req actual=%b expected=%b", tag, irq_req, exp_irq);
    end
    total++;
    if (status !== exp_stat) begin
      bad++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, exp_stat);
    end
  endtask

  // behavioural reference: one clock step
  task automatic model(input logic a, input logic [4:0] f, input logic [6:0] e);
    logic r = 1'b0;
    logic [SW-1:0] s = '0;
    if (e[0]) begin s[10] = 1; if (f[0]) r = 1; end
    if (e[1]) begin s[11] = 1; if (f[1]) r = 1; end
    if (e[2] || e[3]) begin s[12] = 1; if (f[2] && f[3]) r = 1; end
    if (e[4]) begin s[8] = 1; s[12] = 1; if (f[2] && f[3] && !f[4]) r = 1; end
    if (e[5]) begin s[12] = 1; s[14] = 1; if (f[2]) r = 1; end
    if (e[6]) begin s[9] = 1; s[12] = 1; r = 1; end
    if (a) begin
      exp_irq = r;
      exp_stat = s;
    end else begin
      exp_irq = exp_irq | r;
      exp_stat = exp_stat | s;
    end
  endtask

  // drive at negedge, compare at the following negedge
  task automatic step(input string tag, input logic a, input logic [4:0] f,
                      input logic [6:0] e);
    ack = a; fl = f; ev = e;
    model(a, f, e);
    @(negedge clk);
    check(tag);
  endtask

  task automatic clear();
    step("R8", 1'b1, 5'b0, 7'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ack = 0; fl = '0; ev = '0;
    exp_irq = 0; exp_stat = '0;
    repeat (3) @(negedge clk);
    check("R1");
    ev = 7'h7F; fl = 5'h0F;
    @(negedge clk);
    check("R1");                // events ignored while in reset
    ev = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2 count zero
    step("R2", 0, 5'b00000, 7'b0000001);
    step("R2", 0, 5'b00000, 7'b0000000);
    clear();
    step("R2", 0, 5'b00001, 7'b0000001);
    clear();
    // R3 channel end
    step("R3", 0, 5'b11101, 7'b0000010);
    clear();
    step("R3", 0, 5'b00010, 7'b0000010);
    clear();
    // R4 memory error / write lock
    step("R4", 0, 5'b00100, 7'b0000100);
    clear();
    step("R4", 0, 5'b01000, 7'b0001000);
    clear();
    step("R4", 0, 5'b01100, 7'b0001000);
    clear();
    step("R4", 0, 5'b01100, 7'b0000100);
    clear();
    // R5 incorrect length
    step("R5", 0, 5'b11100, 7'b0010000);
    clear();
    step("R5", 0, 5'b01100, 7'b0010000);
    clear();
    step("R5", 0, 5'b00100, 7'b0010000);
    clear();
    // R6 hard error always interrupts
    step("R6", 0, 5'b00000, 7'b1000000);
    clear();
    step("R6", 0, 5'b10000, 7'b1000000);
    clear();
    // R7 halt
    step("R7", 0, 5'b00000, 7'b0100000);
    clear();
    step("R7", 0, 5'b00100, 7'b0100000);
    // R8 sticky across idle cycles, then cleared
    for (int i = 0; i < 5; i++) step("R8", 0, 5'b00000, 7'b0);
    clear();
    step("R8", 0, 5'b11111, 7'b0);
    // R9 event collides with ack while earlier state is pending
    step("R9", 0, 5'b00011, 7'b0000011);
    step("R9", 1, 5'b00000, 7'b0100000);
    step("R9", 0, 5'b00000, 7'b0);
    step("R9", 1, 5'b00001, 7'b0000001);
    clear();
    // R10 mixes: one gated, one enabled
    step("R10", 0, 5'b00001, 7'b0000010);
    step("R10", 0, 5'b00001, 7'b0000001);
    clear();
    step("R10", 0, 5'b11100, 7'b0110110);
    clear();
    // R11 / R12: all events, then check spare bits and timing
    step("R11", 0, 5'b11111, 7'b1111111);
    total++;
    if ((status & ~16'h5F00) !== '0) begin
      bad++;
      $display("FAIL R11 spare bits actual=%h expected=0000", status & ~16'h5F00);
    end
    clear();
    // random phase, many ack collisions
    for (int i = 0; i < 600; i++) begin
      logic a;
      logic [4:0] f;
      logic [6:0] e;
      a = ($urandom % 4) == 0;
      f = 5'($urandom);
      e = 7'($urandom) & 7'($urandom);
      step("R10", a, f, e);
    end
    clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule